// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block is the host-facing side of a PC keyboard controller. A host reaches it over an 8-bit bus. The bus has a chip select, read and write strobes, and one address bit. With the address bit high, a read returns the status byte and a write issues a controller command. With the address bit low, a read or write goes to the data port.

The block owns the input buffer, the output buffer, the command byte and the status byte. Commands are decoded in logic. Some commands produce a reply byte in the output buffer. Others arm a two-byte sequence, where the next data-port write either loads the command byte or goes to the mouse instead of the keyboard. Data bound for a device leaves through a send request to the serial transmitter. The transmitter answers with a completion, which carries the device's reply byte, or with error pulses. The meaning of status bits 5 and 6 depends on whether the controller runs in AT mode or PS/2 mode.

Top module: `kbc_host_if`

## Requirements
- R1: A write strobed with `addr_i`=1 is taken as a command and one with `addr_i`=0 as data. A read with `addr_i`=1 returns the status byte, and a read with `addr_i`=0 returns the output buffer and clears output-buffer-full (status bit 0) at that clock edge.
- R2: Input-buffer-full (status bit 1) reads 1 in the cycle after a host write and 0 from the cycle after that. Status bit 3 is 1 when the last write was a command and 0 when it was data.
- R3: After reset the status byte reads 10h: bit 4 (keyboard not locked) is constant 1, and all other bits are 0. Status bit 2 always equals command-byte bit 2. The command byte resets to 40h.
- R4: Command 20h places the command byte in the output buffer. Command 60h makes the next data write load the command byte, with bit 7 forced to 0.
- R5: Commands AAh, A9h, ABh and A4h place 55h, 00h, 00h and F1h in the output buffer and set output-buffer-full.
- R6: A data write with nothing armed raises `tx_req_o` with `tx_mouse_o`=0 and `tx_data_o` set to the byte. After command D4h, the next data write does the same with `tx_mouse_o`=1. `tx_req_o` stays high until `tx_done_i`.
- R7: In PS/2 mode, A7h sets command-byte bit 5 and drives `mouse_inhibit_o` high, and A8h clears both. In AT mode, both commands leave the command byte and `mouse_inhibit_o` unchanged.
- R8: Command 9xh copies its low nibble to `port_lo_o`, which resets to Fh. A command code that is not defined changes no port, buffer or command-byte state.
- R9: `tx_done_i` during a pending send loads `tx_resp_i` into the output buffer, sets output-buffer-full and drops `tx_req_o`. `kb_irq_o` is output-buffer-full AND a keyboard-sourced byte AND command-byte bit 0. `ms_irq_o` is output-buffer-full AND a mouse-sourced byte AND command-byte bit 1.
- R10: Status bit 7 is a sticky parity error. In AT mode, bit 5 is transmit time-out and bit 6 is receive time-out. In PS/2 mode, bit 5 means the buffered byte came from the mouse, and bit 6 is either time-out. All error flags clear when a new send starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 1 | 1 selects command/status, 0 selects data |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| ps2_mode_i | input | 1 | 1 selects PS/2 mode, 0 selects AT mode |
| tx_req_o | output | 1 | Send pending to the serial transmitter |
| tx_mouse_o | output | 1 | Pending send targets the mouse |
| tx_data_o | output | 8 | Byte to send |
| tx_done_i | input | 1 | Transmission complete pulse |
| tx_resp_i | input | 8 | Device reply byte, valid with tx_done_i |
| parity_err_i | input | 1 | Parity error pulse |
| tx_tmo_i | input | 1 | Transmit time-out pulse |
| rx_tmo_i | input | 1 | Receive time-out pulse |
| kb_irq_o | output | 1 | Keyboard-side buffer-full interrupt |
| ms_irq_o | output | 1 | Mouse-side buffer-full interrupt |
| port_lo_o | output | 4 | General port bits 3..0 |
| mouse_inhibit_o | output | 1 | Mouse interface inhibit |

## Verification
The assertions assume three things about the inputs. Every strobe lasts one cycle. A second host write never arrives while the first byte is still in the input buffer. `ps2_mode_i` changes only while the bus is idle. The bench spaces each access at least four cycles apart and changes mode only between scenarios. It raises `tx_done_i` only while a send is pending and never in a cycle where the decoder also writes a reply.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    ARM_NONE  = 2'd0,
    ARM_CBYTE = 2'd1,
    ARM_MOUSE = 2'd2
  } arm_e;

  localparam logic [7:0] OP_RD_CB   = 8'h20;
  localparam logic [7:0] OP_WR_CB   = 8'h60;
  localparam logic [7:0] OP_PASSWD  = 8'hA4;
  localparam logic [7:0] OP_MS_OFF  = 8'hA7;
  localparam logic [7:0] OP_MS_ON   = 8'hA8;
  localparam logic [7:0] OP_MS_TEST = 8'hA9;
  localparam logic [7:0] OP_SELF    = 8'hAA;
  localparam logic [7:0] OP_KB_TEST = 8'hAB;
  localparam logic [7:0] OP_TO_MS   = 8'hD4;
  localparam logic [3:0] OP_PORT_HI = 4'h9;

  localparam logic [7:0] CB_RESET   = 8'h40;
endpackage

// File: rtl/kbc_bus_port.sv
module kbc_bus_port
  import kbc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          consume_i,
  output logic [DW-1:0] ibuf_o,
  output logic          ibf_o,
  output logic          is_cmd_o,
  output logic          data_rd_o
);
  logic host_wr;
  assign host_wr   = cs_i & wr_i;
  assign data_rd_o = cs_i & rd_i & ~addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibuf_o   <= '0;
      ibf_o    <= 1'b0;
      is_cmd_o <= 1'b0;
    end else if (host_wr) begin
      ibuf_o   <= wdata_i;
      ibf_o    <= 1'b1;
      is_cmd_o <= addr_i;
    end else if (consume_i) begin
      ibf_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
#(
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ibf_i,
  input  logic [DW-1:0] ibuf_i,
  input  logic          is_cmd_i,
  input  logic          ps2_mode_i,
  output logic          consume_o,
  output logic [DW-1:0] cbyte_o,
  output logic [PW-1:0] port_lo_o,
  output logic          mouse_inhibit_o,
  output logic          resp_valid_o,
  output logic [DW-1:0] resp_data_o,
  output logic          send_o,
  output logic          send_mouse_o,
  output logic [DW-1:0] send_data_o
);
  arm_e arm_q;

  assign consume_o = ibf_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q           <= ARM_NONE;
      cbyte_o         <= CB_RESET;
      port_lo_o       <= '1;
      mouse_inhibit_o <= 1'b0;
      resp_valid_o    <= 1'b0;
      resp_data_o     <= '0;
      send_o          <= 1'b0;
      send_mouse_o    <= 1'b0;
      send_data_o     <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      send_o       <= 1'b0;
      if (ibf_i) begin
        arm_q <= ARM_NONE;
        if (is_cmd_i) begin
          if (ibuf_i[7:4] == OP_PORT_HI) begin
            port_lo_o <= ibuf_i[PW-1:0];
          end else begin
            unique case (ibuf_i)
              OP_RD_CB:   begin resp_valid_o <= 1'b1; resp_data_o <= cbyte_o; end
              OP_WR_CB:   arm_q <= ARM_CBYTE;
              OP_TO_MS:   arm_q <= ARM_MOUSE;
              OP_SELF:    begin resp_valid_o <= 1'b1; resp_data_o <= 8'h55; end
              OP_MS_TEST,
              OP_KB_TEST: begin resp_valid_o <= 1'b1; resp_data_o <= 8'h00; end
              OP_PASSWD:  begin resp_valid_o <= 1'b1; resp_data_o <= 8'hF1; end
              OP_MS_OFF:  if (ps2_mode_i) begin
                            cbyte_o[5]      <= 1'b1;
                            mouse_inhibit_o <= 1'b1;
                          end
              OP_MS_ON:   if (ps2_mode_i) begin
                            cbyte_o[5]      <= 1'b0;
                            mouse_inhibit_o <= 1'b0;
                          end
              default: ;  // undefined code: dropped
            endcase
          end
        end else begin
          unique case (arm_q)
            ARM_CBYTE: cbyte_o <= {1'b0, ibuf_i[6:0]};
            ARM_MOUSE: begin
              send_o       <= 1'b1;
              send_mouse_o <= 1'b1;
              send_data_o  <= ibuf_i;
            end
            default: begin
              send_o       <= 1'b1;
              send_mouse_o <= 1'b0;
              send_data_o  <= ibuf_i;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/kbc_out_stage.sv
module kbc_out_stage
  import kbc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_rd_i,
  input  logic          resp_valid_i,
  input  logic [DW-1:0] resp_data_i,
  input  logic          send_i,
  input  logic          send_mouse_i,
  input  logic [DW-1:0] send_data_i,
  input  logic          tx_done_i,
  input  logic [DW-1:0] tx_resp_i,
  input  logic          parity_err_i,
  input  logic          tx_tmo_i,
  input  logic          rx_tmo_i,
  output logic [DW-1:0] obuf_o,
  output logic          obf_o,
  output logic          from_mouse_o,
  output logic          busy_o,
  output logic          tx_mouse_o,
  output logic [DW-1:0] tx_data_o,
  output logic          perr_o,
  output logic          ttmo_o,
  output logic          rtmo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obuf_o       <= '0;
      obf_o        <= 1'b0;
      from_mouse_o <= 1'b0;
      busy_o       <= 1'b0;
      tx_mouse_o   <= 1'b0;
      tx_data_o    <= '0;
      perr_o       <= 1'b0;
      ttmo_o       <= 1'b0;
      rtmo_o       <= 1'b0;
    end else begin
      if (data_rd_i) obf_o <= 1'b0;
      if (resp_valid_i) begin
        obuf_o       <= resp_data_i;
        obf_o        <= 1'b1;
        from_mouse_o <= 1'b0;
      end
      if (tx_done_i && busy_o) begin
        obuf_o       <= tx_resp_i;
        obf_o        <= 1'b1;
        from_mouse_o <= tx_mouse_o;
        busy_o       <= 1'b0;
      end
      if (send_i) begin
        busy_o     <= 1'b1;
        tx_mouse_o <= send_mouse_i;
        tx_data_o  <= send_data_i;
        perr_o     <= 1'b0;
        ttmo_o     <= 1'b0;
        rtmo_o     <= 1'b0;
      end
      if (parity_err_i) perr_o <= 1'b1;
      if (tx_tmo_i)     ttmo_o <= 1'b1;
      if (rx_tmo_i)     rtmo_o <= 1'b1;
    end
  end
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              ps2_mode_i,
  output logic              tx_req_o,
  output logic              tx_mouse_o,
  output logic [DW-1:0]     tx_data_o,
  input  logic              tx_done_i,
  input  logic [DW-1:0]     tx_resp_i,
  input  logic              parity_err_i,
  input  logic              tx_tmo_i,
  input  logic              rx_tmo_i,
  output logic              kb_irq_o,
  output logic              ms_irq_o,
  output logic [PORT_W-1:0] port_lo_o,
  output logic              mouse_inhibit_o
);
  logic [DW-1:0] ibuf, cbyte, resp_data, send_data, obuf, status;
  logic ibf, is_cmd, data_rd, consume, resp_valid, send, send_mouse;
  logic obf, from_mouse, perr, ttmo, rtmo;

  kbc_bus_port u_bus (
    .clk_i, .rst_ni, .cs_i, .rd_i, .wr_i, .addr_i, .wdata_i,
    .consume_i (consume),
    .ibuf_o    (ibuf),
    .ibf_o     (ibf),
    .is_cmd_o  (is_cmd),
    .data_rd_o (data_rd)
  );

  kbc_cmd_decode #(.PW(PORT_W)) u_dec (
    .clk_i, .rst_ni,
    .ibf_i           (ibf),
    .ibuf_i          (ibuf),
    .is_cmd_i        (is_cmd),
    .ps2_mode_i,
    .consume_o       (consume),
    .cbyte_o         (cbyte),
    .port_lo_o,
    .mouse_inhibit_o,
    .resp_valid_o    (resp_valid),
    .resp_data_o     (resp_data),
    .send_o          (send),
    .send_mouse_o    (send_mouse),
    .send_data_o     (send_data)
  );

  kbc_out_stage u_out (
    .clk_i, .rst_ni,
    .data_rd_i    (data_rd),
    .resp_valid_i (resp_valid),
    .resp_data_i  (resp_data),
    .send_i       (send),
    .send_mouse_i (send_mouse),
    .send_data_i  (send_data),
    .tx_done_i, .tx_resp_i, .parity_err_i, .tx_tmo_i, .rx_tmo_i,
    .obuf_o       (obuf),
    .obf_o        (obf),
    .from_mouse_o (from_mouse),
    .busy_o       (tx_req_o),
    .tx_mouse_o,
    .tx_data_o,
    .perr_o       (perr),
    .ttmo_o       (ttmo),
    .rtmo_o       (rtmo)
  );

  // bits 5/6 change meaning with mode
  always_comb begin
    status    = '0;
    status[0] = obf;
    status[1] = ibf;
    status[2] = cbyte[2];
    status[3] = is_cmd;
    status[4] = 1'b1;
    status[5] = ps2_mode_i ? (obf & from_mouse) : ttmo;
    status[6] = ps2_mode_i ? (ttmo | rtmo) : rtmo;
    status[7] = perr;
  end

  assign rdata_o  = addr_i ? status : obuf;
  assign kb_irq_o = obf & ~from_mouse & cbyte[0];
  assign ms_irq_o = obf &  from_mouse & cbyte[1];
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk #(
  parameter int unsigned PORT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              wr_i,
  input logic              ibf,
  input logic              obf,
  input logic              resp_valid,
  input logic              send,
  input logic              ps2_mode_i,
  input logic              mouse_inhibit_o,
  input logic [PORT_W-1:0] port_lo_o,
  input logic              is_cmd,
  input logic              tx_req_o,
  input logic              tx_done_i
);
  AST_IBF_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibf && !(cs_i && wr_i) |=> !ibf); // R2
  AST_REPLY_SETS_OBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid |=> obf); // R5
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && !tx_done_i && !send |=> tx_req_o); // R6
  AST_AT_MOUSE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ps2_mode_i |=> $stable(mouse_inhibit_o)); // R7
  AST_PORT_ONLY_BY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ibf && is_cmd) |=> $stable(port_lo_o)); // R8
endmodule

bind kbc_host_if kbc_host_if_chk #(.PORT_W(PORT_W)) u_chk (
  .clk_i, .rst_ni, .cs_i, .wr_i,
  .ibf, .obf, .resp_valid, .send,
  .ps2_mode_i, .mouse_inhibit_o, .port_lo_o, .is_cmd,
  .tx_req_o, .tx_done_i
);

// File: tb/kbc_host_if_test.sv
`timescale 1ns/1ps
module kbc_host_if_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0, addr = 0, ps2 = 0;
  logic [7:0] wd = 0, rdata, txd, tx_resp = 0;
  logic tx_req, tx_ms, tx_done = 0, perr = 0, ttmo = 0, rtmo = 0;
  logic kb_irq, ms_irq, ms_inh;
  logic [3:0] plo;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  kbc_host_if uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wd), .rdata_o(rdata), .ps2_mode_i(ps2),
    .tx_req_o(tx_req), .tx_mouse_o(tx_ms), .tx_data_o(txd),
    .tx_done_i(tx_done), .tx_resp_i(tx_resp), .parity_err_i(perr),
    .tx_tmo_i(ttmo), .rx_tmo_i(rtmo), .kb_irq_o(kb_irq), .ms_irq_o(ms_irq),
    .port_lo_o(plo), .mouse_inhibit_o(ms_inh)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bwr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wd = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  // drives at current negedge, samples, strobe spans one edge
  task automatic brd(input logic a, output logic [7:0] d);
    cs = 1; rd = 1; addr = a; #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic settle; repeat (4) @(negedge clk); endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic t_reset;
    @(negedge clk); brd(1, v);
    chk("R3 reset status", v, 8'h10);
    chk("R8 reset port", {4'h0, plo}, 8'h0F);
    chk("R6 no req at reset", {7'h0, tx_req}, 8'h00);
  endtask

  task automatic t_ibf_undef;
    bwr(1, 8'hFF); brd(1, v);
    chk("R2 ibf set, cmd flag", v, 8'h1A);
    settle; brd(1, v);
    chk("R2 ibf cleared", v, 8'h18);
    chk("R8 undefined cmd leaves port", {4'h0, plo}, 8'h0F);
    bwr(1, 8'h20); settle; brd(0, v);
    chk("R8 undefined cmd leaves cbyte", v, 8'h40);
  endtask

  task automatic t_cbyte;
    bwr(1, 8'h60); settle; bwr(0, 8'hC7); settle;
    brd(1, v); chk("R2 data write clears cmd flag", v & 8'h0B, 8'h00);
    chk("R3 sys flag mirrors cbyte", v & 8'h04, 8'h04);
    bwr(1, 8'h20); settle; brd(1, v);
    chk("R4 obf after 20h", v, 8'h1D);
    brd(0, v); chk("R4 cbyte bit7 cleared", v, 8'h47);
    settle; brd(1, v); chk("R1 data read clears obf", v, 8'h1C);
  endtask

  task automatic t_replies;
    logic [7:0] ops [4] = '{8'hAA, 8'hA9, 8'hAB, 8'hA4};
    logic [7:0] exp [4] = '{8'h55, 8'h00, 8'h00, 8'hF1};
    for (int i = 0; i < 4; i++) begin
      bwr(1, ops[i]); settle; brd(1, v);
      chk("R5 obf set", v & 8'h01, 8'h01);
      brd(0, v); chk("R5 reply byte", v, exp[i]);
    end
  endtask

  task automatic t_port;
    bwr(1, 8'h95); settle; chk("R8 port nibble", {4'h0, plo}, 8'h05);
    bwr(1, 8'h9A); settle; chk("R8 port nibble 2", {4'h0, plo}, 8'h0A);
  endtask

  task automatic t_kb_send;
    bwr(1, 8'h60); settle; bwr(0, 8'h03); settle;
    chk("R6 cbyte write no send", {7'h0, tx_req}, 8'h00);
    bwr(0, 8'hED); settle;
    chk("R6 kb req", {6'h0, tx_req, tx_ms}, 8'h02);
    chk("R6 kb data", txd, 8'hED);
    settle; chk("R6 req held", {7'h0, tx_req}, 8'h01);
    tx_resp = 8'hFA; pulse(tx_done);
    chk("R9 req drops", {7'h0, tx_req}, 8'h00);
    chk("R9 kb irq", {6'h0, kb_irq, ms_irq}, 8'h02);
    brd(0, v); chk("R9 device reply", v, 8'hFA);
    chk("R9 irq clears on read", {6'h0, kb_irq, ms_irq}, 8'h00);
  endtask

  task automatic t_ms_send;
    ps2 = 1;
    bwr(1, 8'hD4); settle; bwr(0, 8'hF4); settle;
    chk("R6 mouse req", {6'h0, tx_req, tx_ms}, 8'h03);
    chk("R6 mouse data", txd, 8'hF4);
    tx_resp = 8'hFA; pulse(tx_done);
    chk("R9 ms irq", {6'h0, kb_irq, ms_irq}, 8'h01);
    brd(1, v); chk("R10 ps2 bit5 mouse byte", v & 8'h21, 8'h21);
    brd(0, v); chk("R9 mouse reply", v, 8'hFA);
    bwr(0, 8'h11); settle;
    chk("R6 D4 applies once", {6'h0, tx_req, tx_ms}, 8'h02);
    pulse(tx_done); brd(0, v);
    ps2 = 0;
  endtask

  task automatic t_mouse_en;
    ps2 = 0;
    bwr(1, 8'hA7); settle;
    chk("R7 AT no inhibit", {7'h0, ms_inh}, 8'h00);
    bwr(1, 8'h20); settle; brd(0, v); chk("R7 AT cbyte kept", v, 8'h03);
    ps2 = 1;
    bwr(1, 8'hA7); settle;
    chk("R7 ps2 inhibit", {7'h0, ms_inh}, 8'h01);
    bwr(1, 8'h20); settle; brd(0, v); chk("R7 ps2 bit5 set", v, 8'h23);
    ps2 = 0;
    bwr(1, 8'hA8); settle;
    chk("R7 AT A8 no effect", {7'h0, ms_inh}, 8'h01);
    ps2 = 1;
    bwr(1, 8'hA8); settle;
    chk("R7 ps2 enable", {7'h0, ms_inh}, 8'h00);
    bwr(1, 8'h20); settle; brd(0, v); chk("R7 ps2 bit5 clear", v, 8'h03);
    ps2 = 0;
  endtask

  task automatic t_errors;
    ps2 = 0;
    pulse(ttmo); brd(1, v); chk("R10 AT tx timeout bit5", v & 8'hE0, 8'h20);
    pulse(rtmo); brd(1, v); chk("R10 AT rx timeout bit6", v & 8'hE0, 8'h60);
    pulse(perr); brd(1, v); chk("R10 parity bit7", v & 8'hE0, 8'hE0);
    ps2 = 1; @(negedge clk); brd(1, v);
    chk("R10 ps2 general timeout", v & 8'hE0, 8'hC0);
    ps2 = 0;
    bwr(0, 8'h55); settle; brd(1, v);
    chk("R10 flags clear on send", v & 8'hE0, 8'h00);
    pulse(tx_done); brd(0, v);
    ps2 = 1; pulse(ttmo); brd(1, v);
    chk("R10 ps2 tx timeout to bit6", v & 8'hE0, 8'h40);
    ps2 = 0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset;
    t_ibf_undef;
    t_cbyte;
    t_replies;
    t_port;
    t_kb_send;
    t_ms_send;
    t_mouse_en;
    t_errors;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule